// File: doc/BRIEF.md
# Lockable Two-Way Data Cache Controller

This block is a 16 KB, two-way set-associative data cache that sits between a simple load/store port and a 32-bit memory port. The set is chosen from low virtual address bits while the physical tag for the same access arrives in the same cycle, so lookup and translation can run in parallel upstream. Each access carries a write-policy attribute: write-back stores stay in the cache and mark the line dirty, while write-through stores always produce a memory write and never allocate on a miss.

On an allocating miss the controller writes back a dirty victim, if there is one, and then fetches the line. The fetch starts at the requested word and wraps around, and a load is answered as soon as that first word arrives, while the rest of the line is still being fetched. Replacement follows one least-recently-used bit per set. A two-bit lock input keeps either way out of replacement. When both ways are locked, a miss goes straight to memory as a single-word access.

Top module: `dcache_lockable`

## Requirements
- R1: The geometry is 2 ways of 256 sets with 32-byte lines, which gives 8 words per line. `cpu_idx[10:3]` selects the set and `cpu_idx[2:0]` selects the word. Every memory address is the byte address `{tag[18:0], set[7:0], word[2:0], 2'b00}`.
- R2: A load that hits returns the stored word with `rsp_valid` high in the cycle after acceptance. `cpu_ready` stays high and there is no memory traffic.
- R3: A write-back store that hits updates the word and marks the line dirty. It makes no memory access and is answered in the cycle after acceptance.
- R4: A write-through store (`cpu_wthru`=1) issues exactly one memory write of the word to its physical address. On a hit it also updates the cached word. On a miss it allocates nothing, so a later load of that line misses.
- R5: A line fill issues eight memory reads. They start at the requested word and continue in ascending word order, wrapping modulo 8.
- R6: A load miss is answered in the cycle after the first fill beat is acknowledged, with that beat's data. `cpu_ready` stays low until the fill ends.
- R7: Before a fill, a victim that is valid and dirty is written back as eight memory writes of words 0 to 7 to the victim's own address.
- R8: The victim is the least recently used way of the set. A way whose `lock_way` bit is 1 is never chosen, so a locked LRU way passes the eviction to the other way.
- R9: With both `lock_way` bits set, a miss allocates nothing. A load performs one memory read and returns that data. A write-back store performs one memory write.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` hold their values. `cpu_ready` is low whenever `mem_req` is high.
- R11: After reset `cpu_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, and every line is invalid.
- R12: A write-back store miss allocates the line. The fill merges the store data and leaves the line dirty, so its later eviction writes the stored word back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_wthru | input | 1 | Page attribute: 1 = write-through, 0 = write-back |
| cpu_idx | input | 11 | Virtual set and word index |
| cpu_ptag | input | 19 | Physical tag for the access |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid |
| lock_way | input | 2 | Per-way replacement lock |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_ack | input | 1 | Beat completes on this cycle |
| mem_rdata | input | 32 | Read beat data, valid with mem_ack |

## Verification
A fixed directed sequence on one set covers each separate path. It compares a load hit against a load miss, to show the single-cycle answer and the wrapped critical-word-first fill. It compares write-back stores against write-through stores, to show that only the latter reach memory, and it evicts a clean victim and then a dirty one, to show that only the dirty line is written back. The lock input is walked through each of its four values, and follow-up hits show which way survived. A random mix of loads and stores over four tags and four sets then follows, with latency that varies per beat, random policy attributes and changing locks. Every load result is checked against a shadow copy of memory as the processor sees it.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WBACK = 3'd1,
    ST_FILL  = 3'd2,
    ST_MEMWR = 3'd3,
    ST_MEMRD = 3'd4
  } dc_state_e;
endpackage

// File: rtl/dc_rst_sync.sv
module dc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int TAG_W = 19,
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   look_idx,
  input  logic [TAG_W-1:0]   look_tag,
  output logic [1:0]         hit,
  output logic [2*TAG_W-1:0] rd_tag,
  output logic [1:0]         rd_valid,
  output logic [1:0]         rd_dirty,
  output logic               rd_lru,
  input  logic               upd_en,
  input  logic               upd_way,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic [TAG_W-1:0]   upd_tag,
  input  logic               upd_dirty,
  input  logic               lru_en,
  input  logic [IDX_W-1:0]   lru_idx,
  input  logic               lru_used
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic             sel;

    assign sel = upd_en && (upd_way == 1'(w));

    always_ff @(posedge clk) begin
      if (sel) tag_mem[upd_idx] <= upd_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (sel) begin
        vld_q[upd_idx] <= 1'b1;
        drt_q[upd_idx] <= upd_dirty;
      end
    end

    assign rd_tag[w*TAG_W +: TAG_W] = tag_mem[look_idx];
    assign rd_valid[w] = vld_q[look_idx];
    assign rd_dirty[w] = drt_q[look_idx];
    assign hit[w]      = vld_q[look_idx] && (tag_mem[look_idx] == look_tag);
  end

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[lru_idx] <= ~lru_used;
  end

  assign rd_lru = lru_q[look_idx];
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                wr_way,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [OFF_W-1:0]    wr_off,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [OFF_W-1:0]    rd_off,
  output logic [2*DATA_W-1:0] rd_data
);
  localparam int WORDS = 1 << (IDX_W + OFF_W);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] word_mem [WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) word_mem[{wr_idx, wr_off}] <= wr_data;
    end

    assign rd_data[w*DATA_W +: DATA_W] = word_mem[{rd_idx, rd_off}];
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dcache_pkg::*;
#(
  parameter int TAG_W  = 19,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = TAG_W + IDX_W + OFF_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic                   cpu_wthru,
  input  logic [IDX_W+OFF_W-1:0] cpu_idx,
  input  logic [TAG_W-1:0]       cpu_ptag,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic                   cpu_ready,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic [1:0]             lock_way,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic                   mem_ack,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic [IDX_W-1:0]       set_sel,
  input  logic [1:0]             hit,
  input  logic [2*TAG_W-1:0]     rd_tag,
  input  logic [1:0]             rd_valid,
  input  logic [1:0]             rd_dirty,
  input  logic                   rd_lru,
  output logic                   upd_en,
  output logic                   upd_way,
  output logic [TAG_W-1:0]       upd_tag,
  output logic                   upd_dirty,
  output logic                   lru_en,
  output logic                   lru_used,
  output logic [OFF_W-1:0]       d_rd_off,
  input  logic [2*DATA_W-1:0]    d_rd_data,
  output logic                   d_wr_en,
  output logic                   d_wr_way,
  output logic [OFF_W-1:0]       d_wr_off,
  output logic [DATA_W-1:0]      d_wr_data
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'((1 << OFF_W) - 1);
  localparam logic [OFF_W-1:0] ONE_BEAT  = OFF_W'(1);

  dc_state_e          state_q, state_d;
  logic [OFF_W-1:0]   cnt_q, cnt_d;
  logic               vic_q, vic_d;
  logic [TAG_W-1:0]   vtag_q, vtag_d;
  logic               rspv_q, rspv_d;
  logic [DATA_W-1:0]  rspd_q, rspd_d;

  logic               req_we_q;
  logic [IDX_W-1:0]   req_idx_q;
  logic [OFF_W-1:0]   req_off_q;
  logic [TAG_W-1:0]   req_tag_q;
  logic [DATA_W-1:0]  req_wdata_q;

  logic               idle, accept, hit_any, hit_way, pick, can_alloc, last;
  logic [IDX_W-1:0]   cpu_set;
  logic [OFF_W-1:0]   cpu_off, fill_off;
  logic [DATA_W-1:0]  hit_word, vic_word;
  logic [TAG_W-1:0]   pick_tag;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && cpu_req;
  assign cpu_set   = cpu_idx[OFF_W +: IDX_W];
  assign cpu_off   = cpu_idx[OFF_W-1:0];
  assign hit_any   = |hit;
  assign hit_way   = hit[1];
  assign pick      = lock_way[rd_lru] ? ~rd_lru : rd_lru;
  assign can_alloc = ~(lock_way[0] & lock_way[1]);
  assign pick_tag  = pick ? rd_tag[2*TAG_W-1:TAG_W] : rd_tag[TAG_W-1:0];
  assign hit_word  = hit_way ? d_rd_data[2*DATA_W-1:DATA_W] : d_rd_data[DATA_W-1:0];
  assign vic_word  = vic_q ? d_rd_data[2*DATA_W-1:DATA_W] : d_rd_data[DATA_W-1:0];
  assign fill_off  = req_off_q + cnt_q;
  assign last      = (cnt_q == LAST_BEAT);

  assign set_sel   = idle ? cpu_set : req_idx_q;
  assign d_rd_off  = idle ? cpu_off : ((state_q == ST_WBACK) ? cnt_q : req_off_q);
  assign d_wr_off  = idle ? cpu_off : fill_off;
  assign upd_tag   = idle ? cpu_ptag : req_tag_q;

  assign cpu_ready = idle;
  assign rsp_valid = rspv_q;
  assign rsp_rdata = rspd_q;

  // request capture, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (accept) begin
      req_we_q    <= cpu_we;
      req_idx_q   <= cpu_set;
      req_off_q   <= cpu_off;
      req_tag_q   <= cpu_ptag;
      req_wdata_q <= cpu_wdata;
    end
  end

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    vic_d     = vic_q;
    vtag_d    = vtag_q;
    rspv_d    = 1'b0;
    rspd_d    = rspd_q;
    upd_en    = 1'b0;
    upd_way   = vic_q;
    upd_dirty = 1'b0;
    lru_en    = 1'b0;
    lru_used  = vic_q;
    d_wr_en   = 1'b0;
    d_wr_way  = vic_q;
    d_wr_data = mem_rdata;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {req_tag_q, req_idx_q, req_off_q, 2'b00};
    mem_wdata = req_wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (hit_any) begin
            lru_en   = 1'b1;
            lru_used = hit_way;
            if (!cpu_we) begin
              rspv_d = 1'b1;
              rspd_d = hit_word;
            end else begin
              d_wr_en   = 1'b1;
              d_wr_way  = hit_way;
              d_wr_data = cpu_wdata;
              if (cpu_wthru) begin
                state_d = ST_MEMWR;
              end else begin
                upd_en    = 1'b1;
                upd_way   = hit_way;
                upd_dirty = 1'b1;
                rspv_d    = 1'b1;
              end
            end
          end else if (cpu_we && cpu_wthru) begin
            state_d = ST_MEMWR;
          end else if (!can_alloc) begin
            state_d = cpu_we ? ST_MEMWR : ST_MEMRD;
          end else begin
            vic_d   = pick;
            vtag_d  = pick_tag;
            cnt_d   = '0;
            state_d = (rd_valid[pick] && rd_dirty[pick]) ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {vtag_q, req_idx_q, cnt_q, 2'b00};
        mem_wdata = vic_word;
        if (mem_ack) begin
          cnt_d = cnt_q + ONE_BEAT;
          if (last) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {req_tag_q, req_idx_q, fill_off, 2'b00};
        if (mem_ack) begin
          d_wr_en = 1'b1;
          cnt_d   = cnt_q + ONE_BEAT;
          if (cnt_q == '0) begin
            if (req_we_q) begin
              d_wr_data = req_wdata_q;
            end else begin
              rspv_d = 1'b1;
              rspd_d = mem_rdata;
            end
          end
          if (last) begin
            upd_en    = 1'b1;
            upd_dirty = req_we_q;
            lru_en    = 1'b1;
            rspv_d    = req_we_q;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_MEMWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          rspv_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_MEMRD: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          rspv_d  = 1'b1;
          rspd_d  = mem_rdata;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vic_q   <= 1'b0;
      vtag_q  <= '0;
      rspv_q  <= 1'b0;
      rspd_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vic_q   <= vic_d;
      vtag_q  <= vtag_d;
      rspv_q  <= rspv_d;
      rspd_q  <= rspd_d;
    end
  end
endmodule

// File: rtl/dcache_lockable.sv
module dcache_lockable #(
  parameter int TAG_W  = 19,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic                        cpu_wthru,
  input  logic [IDX_W+OFF_W-1:0]      cpu_idx,
  input  logic [TAG_W-1:0]            cpu_ptag,
  input  logic [DATA_W-1:0]           cpu_wdata,
  output logic                        cpu_ready,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  input  logic [1:0]                  lock_way,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [TAG_W+IDX_W+OFF_W+1:0] mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic                        mem_ack,
  input  logic [DATA_W-1:0]           mem_rdata
);
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W + 2;

  logic                 rst_n_s;
  logic [IDX_W-1:0]     set_sel;
  logic [1:0]           tag_hit, rd_valid, rd_dirty;
  logic [2*TAG_W-1:0]   rd_tag;
  logic                 rd_lru;
  logic                 upd_en, upd_way, upd_dirty, lru_en, lru_used;
  logic [TAG_W-1:0]     upd_tag;
  logic [OFF_W-1:0]     d_rd_off, d_wr_off;
  logic [2*DATA_W-1:0]  d_rd_data;
  logic                 d_wr_en, d_wr_way;
  logic [DATA_W-1:0]    d_wr_data;

  dc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  dc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n_s),
    .look_idx(set_sel), .look_tag(cpu_ptag),
    .hit(tag_hit), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_lru(rd_lru),
    .upd_en(upd_en), .upd_way(upd_way), .upd_idx(set_sel), .upd_tag(upd_tag), .upd_dirty(upd_dirty),
    .lru_en(lru_en), .lru_idx(set_sel), .lru_used(lru_used)
  );

  dc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .wr_en(d_wr_en), .wr_way(d_wr_way), .wr_idx(set_sel), .wr_off(d_wr_off), .wr_data(d_wr_data),
    .rd_idx(set_sel), .rd_off(d_rd_off), .rd_data(d_rd_data)
  );

  dc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wthru(cpu_wthru), .cpu_idx(cpu_idx),
    .cpu_ptag(cpu_ptag), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lock_way(lock_way),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .set_sel(set_sel), .hit(tag_hit), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .rd_dirty(rd_dirty), .rd_lru(rd_lru),
    .upd_en(upd_en), .upd_way(upd_way), .upd_tag(upd_tag), .upd_dirty(upd_dirty),
    .lru_en(lru_en), .lru_used(lru_used),
    .d_rd_off(d_rd_off), .d_rd_data(d_rd_data),
    .d_wr_en(d_wr_en), .d_wr_way(d_wr_way), .d_wr_off(d_wr_off), .d_wr_data(d_wr_data)
  );
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_wthru,
  input logic              cpu_ready,
  input logic [1:0]        lock_way,
  input logic [1:0]        hit,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  logic take;
  assign take = cpu_req && cpu_ready;

  a_r10_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r10_busy_when_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r2_load_hit_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cpu_we && (|hit)) |=> (rsp_valid && cpu_ready && !mem_req));

  a_r3_wb_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_we && !cpu_wthru && (|hit)) |=> (rsp_valid && !mem_req));

  a_r4_wt_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_we && cpu_wthru) |=> (mem_req && mem_we));

  a_r9_bypass_load: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cpu_we && !(|hit) && (&lock_way)) |=> (mem_req && !mem_we));
endmodule

bind dcache_lockable dc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wthru(cpu_wthru),
  .cpu_ready(cpu_ready), .lock_way(lock_way), .hit(tag_hit), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/test_dcache_lockable.sv
module test_dcache_lockable;
  localparam int TAG_W = 19;
  localparam int IDX_W = 8;
  localparam int OFF_W = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cpu_req, cpu_we, cpu_wthru, cpu_ready, rsp_valid;
  logic [IDX_W+OFF_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_ptag;
  logic [31:0] cpu_wdata, rsp_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [1:0] lock_way;
  logic mem_req, mem_we, mem_ack;

  dcache_lockable i_dcache_lockable (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wthru(cpu_wthru),
    .cpu_idx(cpu_idx), .cpu_ptag(cpu_ptag), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lock_way(lock_way),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0, hold_viol = 0, lat = 0;
  bit done = 0;
  logic [31:0] mmem [int unsigned];
  logic [31:0] shadow [int unsigned];
  logic [31:0] lg_addr[$];
  logic [31:0] lg_data[$];
  logic        lg_we[$];
  logic        pend_q = 1'b0;
  logic [31:0] pend_addr = '0;
  int          last_lat;
  bit          last_busy;
  logic [31:0] last_rd;

  function automatic logic [31:0] seed_val(int unsigned a);
    return (a * 32'h9E37_79B1) ^ 32'h3C6E_F372;
  endfunction
  function automatic logic [31:0] mem_get(int unsigned a);
    return mmem.exists(a) ? mmem[a] : seed_val(a);
  endfunction
  function automatic logic [31:0] shd_get(int unsigned a);
    return shadow.exists(a) ? shadow[a] : seed_val(a);
  endfunction
  function automatic int unsigned paddr(int tag, int set, int w);
    return (tag << (IDX_W + OFF_W + 2)) | (set << (OFF_W + 2)) | ((w % 8) << 2);
  endfunction

  // memory responder with 0..2 cycles of wait per beat
  always @(negedge clk) begin
    if (pend_q && (!mem_req || mem_addr != pend_addr)) hold_viol++;
    if (rst_n && mem_req) begin
      if (lat == 0) begin
        mem_ack = 1'b1;
        lg_addr.push_back(mem_addr);
        lg_we.push_back(mem_we);
        if (mem_we) begin
          mmem[mem_addr] = mem_wdata;
          lg_data.push_back(mem_wdata);
        end else begin
          mem_rdata = mem_get(mem_addr);
          lg_data.push_back(mem_rdata);
        end
        lat = $urandom_range(0, 2);
      end else begin
        mem_ack = 1'b0;
        lat--;
      end
    end else begin
      mem_ack = 1'b0;
    end
    pend_q    = mem_req && !mem_ack;
    pend_addr = mem_addr;
  end

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic clr_log();
    lg_addr.delete(); lg_data.delete(); lg_we.delete();
  endtask

  task automatic access(bit we, bit wt, int tag, int set, int w, logic [31:0] wd);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_wthru = wt;
    cpu_ptag = TAG_W'(tag); cpu_idx = {IDX_W'(set), OFF_W'(w)}; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    last_lat = 1;
    while (!rsp_valid && last_lat < 1000) begin
      @(negedge clk);
      last_lat++;
    end
    last_rd   = rsp_rdata;
    last_busy = !cpu_ready;
    if (we) shadow[paddr(tag, set, w)] = wd;
    while (!cpu_ready) @(negedge clk);
  endtask

  task automatic ld(int tag, int set, int w, string rq);
    access(1'b0, $urandom_range(0, 1) == 1, tag, set, w, '0);
    chk(last_rd == shd_get(paddr(tag, set, w)), rq, "load data", last_rd, shd_get(paddr(tag, set, w)));
  endtask

  task automatic chk_fill(int base, int tag, int set, int start, string rq);
    for (int i = 0; i < 8; i++) begin
      chk((lg_we[base+i] == 1'b0) && (lg_addr[base+i] == paddr(tag, set, start + i)), rq,
          "fill beat address", lg_addr[base+i], paddr(tag, set, start + i));
    end
  endtask

  task automatic chk_cnt(int n, string rq, string what);
    chk(lg_addr.size() == n, rq, what, lg_addr.size(), n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_wthru = 1'b0;
    cpu_idx = '0; cpu_ptag = '0; cpu_wdata = '0; lock_way = 2'b00;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(cpu_ready == 1'b1, "R11", "cpu_ready", cpu_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid", rsp_valid, 0);
    chk(mem_req == 1'b0, "R11", "mem_req", mem_req, 0);

    // R5/R6 load miss, critical word first, early answer
    clr_log();
    ld(1, 5, 3, "R6");
    chk(last_busy, "R6", "busy at early answer", last_busy, 1);
    chk_cnt(8, "R5", "fill beat count");
    chk(lg_addr[0] == 32'h0000_20AC, "R1", "address layout", lg_addr[0], 32'h0000_20AC);
    chk_fill(0, 1, 5, 3, "R5");

    // R2 load hit
    clr_log();
    ld(1, 5, 6, "R2");
    chk(last_lat == 1, "R2", "hit latency", last_lat, 1);
    chk_cnt(0, "R2", "hit traffic");

    // R3 write-back store hit
    clr_log();
    access(1'b1, 1'b0, 1, 5, 6, 32'hA5A5_0006);
    chk(last_lat == 1, "R3", "store latency", last_lat, 1);
    chk_cnt(0, "R3", "store traffic");
    ld(1, 5, 6, "R3");

    // R4 write-through store hit
    clr_log();
    access(1'b1, 1'b1, 1, 5, 2, 32'h0BAD_0002);
    chk_cnt(1, "R4", "wt hit writes");
    chk(lg_we[0] && lg_addr[0] == paddr(1, 5, 2), "R4", "wt address", lg_addr[0], paddr(1, 5, 2));
    chk(lg_data[0] == 32'h0BAD_0002, "R4", "wt data", lg_data[0], 32'h0BAD_0002);
    clr_log();
    ld(1, 5, 2, "R4");
    chk_cnt(0, "R4", "wt hit kept in cache");

    // R4 write-through store miss does not allocate
    clr_log();
    access(1'b1, 1'b1, 7, 5, 0, 32'h7777_0000);
    chk_cnt(1, "R4", "wt miss writes");
    clr_log();
    ld(7, 5, 0, "R4");
    chk_cnt(8, "R4", "no allocation on wt miss");

    // R7 dirty victim written back before fill
    clr_log();
    ld(2, 5, 0, "R7");
    chk_cnt(16, "R7", "writeback plus fill beats");
    for (int i = 0; i < 8; i++) begin
      chk(lg_we[i] && lg_addr[i] == paddr(1, 5, i), "R7", "victim address", lg_addr[i], paddr(1, 5, i));
      chk(lg_data[i] == shd_get(paddr(1, 5, i)), "R7", "victim data", lg_data[i], shd_get(paddr(1, 5, i)));
    end
    chk_fill(8, 2, 5, 0, "R5");

    // R8 locks steer replacement
    lock_way = 2'b10;
    clr_log();
    ld(3, 5, 1, "R8");
    chk_cnt(8, "R8", "clean victim fill only");
    clr_log();
    ld(7, 5, 0, "R8");
    chk_cnt(0, "R8", "locked way kept");
    clr_log();
    ld(4, 5, 0, "R8");
    ld(7, 5, 3, "R8");
    chk_cnt(8, "R8", "locked way still present");
    lock_way = 2'b01;
    ld(5, 5, 0, "R8");
    clr_log();
    ld(4, 5, 0, "R8");
    chk_cnt(0, "R8", "way0 lock kept line");

    // R9 both ways locked
    lock_way = 2'b11;
    clr_log();
    ld(9, 5, 4, "R9");
    chk_cnt(1, "R9", "single read");
    clr_log();
    ld(9, 5, 4, "R9");
    chk_cnt(1, "R9", "not allocated");
    clr_log();
    access(1'b1, 1'b0, 9, 5, 4, 32'h9999_0004);
    chk_cnt(1, "R9", "single write");
    chk(lg_we[0] == 1'b1, "R9", "write beat", lg_we[0], 1);
    ld(9, 5, 4, "R9");
    clr_log();
    ld(4, 5, 0, "R9");
    chk_cnt(0, "R9", "resident lines kept");

    // R12 write-back store miss allocates and becomes dirty
    lock_way = 2'b00;
    clr_log();
    access(1'b1, 1'b0, 10, 9, 1, 32'h1010_0001);
    chk_cnt(8, "R12", "store miss fill");
    chk_fill(0, 10, 9, 1, "R12");
    clr_log();
    ld(10, 9, 1, "R12");
    chk_cnt(0, "R12", "allocated");
    ld(11, 9, 0, "R12");
    clr_log();
    ld(12, 9, 0, "R12");
    chk_cnt(16, "R12", "dirty eviction");
    chk(lg_we[1] && lg_data[1] == 32'h1010_0001, "R12", "merged word written back", lg_data[1], 32'h1010_0001);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int tg, st, wd;
      tg = $urandom_range(0, 3); st = $urandom_range(0, 3); wd = $urandom_range(0, 7);
      if ($urandom_range(0, 9) == 0) lock_way = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1)
        access(1'b1, $urandom_range(0, 2) == 0, tg, st, wd, $urandom);
      else
        ld(tg, st, wd, "R2");
    end

    chk(hold_viol == 0, "R10", "beat held until ack", hold_viol, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule